// File: doc/BRIEF.md
# Scalar-Destination Vector Reduction Sequencer

This block folds a vector of register-file elements into one scalar accumulator register. It runs one element operation per clock. A request arrives as a one-cycle start pulse with these inputs:

- a vector length
- the base register index of the vector source
- the accumulator register index
- a mapreduce flag
- an opcode
- a register class for the accumulator and a register class for the source

On each step the block reads the accumulator and element `base+i` through two combinational read ports. The ALU combines them, and the block writes the result back to the accumulator at the end of the same cycle. The next step therefore sees the updated accumulator.

The accumulator is a register that is both the destination and one of the sources. When the mapreduce flag is clear, the first element operation ends the loop, as any scalar-destination operation does. When the flag is set, the block walks all elements in ascending index order. Requests are rejected and perform no write in these cases:

- the two register classes differ
- the length is above the maximum
- the opcode is not known

Arithmetic wraps and produces no overflow status. A done pulse closes every request. During that pulse the final accumulator value appears on `result`.

Top module: `vred_scalar_seq`

## Requirements
- R1: With mapreduce set and a legal request of length N (1 to 64), the block writes on exactly N consecutive clocks, and `done` is high in the cycle after the last write. That is N rising edges after the edge that samples `start`.
- R2: Every write targets the accumulator index captured at start. Its data is `acc op element`, where `acc` already holds the result of the previous step.
- R3: With mapreduce clear and length of at least 1, exactly one element operation (element `base`) is performed, and `done` follows one edge later.
- R4: Step i reads element `(base + i) mod 128`, with i rising strictly from 0.
- R5: Register class is 0 for general-purpose and 1 for condition registers. When the accumulator class differs from the source class, the block raises `done` together with `illegal` on the cycle after start and performs no write. Equal classes (including both 1) are legal.
- R6: A length above 64, or an opcode code of 5, 6 or 7, is rejected exactly as in R5.
- R7: A legal request of length 0 gives `done` on the cycle after start, with `illegal` low and no write.
- R8: The opcode codes are as follows, all modulo 2^32, with no write to any register other than the accumulator:

  | Code | Operation |
  |------|-----------|
  | 0 | add |
  | 1 | subtract (acc minus element) |
  | 2 | OR |
  | 3 | unsigned min |
  | 4 | unsigned max |

- R9: A `start` pulse while `busy` is high has no effect on the running request. It is not queued.
- R10: `done` lasts one cycle. `result` equals the accumulator register when `done` is high and `illegal` is low, and is 0 otherwise. `illegal` is high only together with `done`.
- R11: While reset is held, and in the cycle after it, `busy`, `done`, `illegal` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, sampled while idle |
| vl | input | 7 | Vector length, 0 to 64 |
| base_idx | input | 7 | Register index of element 0 |
| acc_idx | input | 7 | Accumulator register index |
| acc_cls | input | 1 | Accumulator register class (0 general, 1 condition) |
| src_cls | input | 1 | Vector source register class |
| mapreduce | input | 1 | 1: walk all elements; 0: stop after the first |
| opcode | input | 3 | Operation code (R8) |
| rf_raddr_acc | output | 7 | Accumulator read address |
| rf_rdata_acc | input | 32 | Accumulator read data (combinational) |
| rf_raddr_elem | output | 7 | Element read address |
| rf_rdata_elem | input | 32 | Element read data (combinational) |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 7 | Register write address |
| rf_wdata | output | 32 | Register write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Request rejected, valid with done |
| result | output | 32 | Final accumulator value, valid with done |

## Verification
A legal request of N steps writes in the N cycles that follow the edge that samples `start`, and its `done` is due exactly N edges after that edge. Rejected and zero-length requests have N equal to 0. The bench drives at falling edges and counts falling edges from the start-sampling edge until `done`. It compares that count with N from the vector table, then reads `illegal` and `result` in the same half-cycle. Writes are logged at rising edges and compared after `done`. The bench also checks that `done` has dropped one cycle later.

// File: rtl/vred_pkg.sv
// Shared types for the scalar-destination reduction sequencer.
// Assumes opcode codes are contiguous from zero; any code above OP_LAST is illegal.
package vred_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_OR   = 3'd2,
        OP_MINU = 3'd3,
        OP_MAXU = 3'd4
    } vred_op_e;

    localparam logic [2:0] OP_LAST = 3'd4;

    typedef enum logic {
        CLS_GPR = 1'b0,
        CLS_CR  = 1'b1
    } reg_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/vred_alu.sv
// Combinational element ALU: folds one element into the accumulator.
// Assumes illegal codes never reach it (the controller rejects them);
// no carry or overflow is produced, results wrap modulo 2^XLEN.
module vred_alu #(
    parameter int XLEN = 32
) (
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] acc,
    input  logic [XLEN-1:0] elem,
    output logic [XLEN-1:0] y
);
    import vred_pkg::*;

    // Select the operation named by the opcode
    always_comb begin
        unique case (op)
            OP_ADD:  y = acc + elem;
            OP_SUB:  y = acc - elem;
            OP_OR:   y = acc | elem;
            OP_MINU: y = (acc < elem) ? acc : elem;
            OP_MAXU: y = (acc > elem) ? acc : elem;
            default: y = acc;
        endcase
    end
endmodule

// File: rtl/vred_addr.sv
// Element address generator: base index plus step index, wrapping
// modulo the register-file depth (a power of two of 2^AW entries).
// Assumes the step counter is never wider than needed for VL_MAX.
module vred_addr #(
    parameter int AW  = 7,
    parameter int VLW = 7
) (
    input  logic [AW-1:0]  base,
    input  logic [VLW-1:0] idx,
    output logic [AW-1:0]  elem_addr
);
    logic [AW-1:0] idx_fit;

    // Fit the step index to the address width
    generate
        if (VLW >= AW) begin : g_trunc
            assign idx_fit = idx[AW-1:0];
        end else begin : g_ext
            assign idx_fit = {{(AW-VLW){1'b0}}, idx};
        end
    endgenerate

    // Wrapping add gives ascending program-order addresses
    assign elem_addr = base + idx_fit;
endmodule

// File: rtl/vred_ctrl.sv
// Sequencing controller: checks legality at start, captures the request,
// counts element steps and closes each request with a one-cycle done.
// Assumes start is only looked at while idle; later pulses are dropped.
module vred_ctrl #(
    parameter int AW     = 7,
    parameter int VLW    = 7,
    parameter int VL_MAX = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [VLW-1:0] vl,
    input  logic [AW-1:0]  base_idx,
    input  logic [AW-1:0]  acc_idx,
    input  logic           acc_cls,
    input  logic           src_cls,
    input  logic           mapreduce,
    input  logic [2:0]     opcode,
    output logic           step,
    output logic           busy,
    output logic           done,
    output logic           illegal,
    output logic [VLW-1:0] idx,
    output logic [AW-1:0]  base_q,
    output logic [AW-1:0]  acc_q,
    output logic [2:0]     op_q
);
    import vred_pkg::*;

    localparam logic [VLW-1:0] VL_LIM = VLW'(VL_MAX);

    seq_state_e     state;
    logic [VLW-1:0] last_q;
    logic           illegal_q;
    logic           req_bad;
    logic           req_empty;

    // Legality of the request presented with start
    always_comb begin
        req_bad   = (acc_cls != src_cls) || (vl > VL_LIM) || (opcode > OP_LAST);
        req_empty = (vl == '0);
    end

    // State, step counter and captured request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            last_q    <= '0;
            base_q    <= '0;
            acc_q     <= '0;
            op_q      <= '0;
            illegal_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        base_q    <= base_idx;
                        acc_q     <= acc_idx;
                        op_q      <= opcode;
                        idx       <= '0;
                        illegal_q <= req_bad;
                        last_q    <= mapreduce ? (vl - VLW'(1)) : '0;
                        state     <= (req_bad || req_empty) ? ST_DONE : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (idx == last_q) begin
                        state <= ST_DONE;
                    end else begin
                        idx <= idx + VLW'(1);
                    end
                end
                ST_DONE: begin
                    illegal_q <= 1'b0;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode state into control outputs
    always_comb begin
        step    = (state == ST_RUN);
        busy    = (state != ST_IDLE);
        done    = (state == ST_DONE);
        illegal = (state == ST_DONE) && illegal_q;
    end
endmodule

// File: rtl/vred_scalar_seq.sv
// Top of the scalar-destination reduction sequencer. It ties the controller,
// address generator and ALU to an external register-file port with two
// combinational reads and one write that takes effect at the clock edge.
// Assumes the register file returns read data in the same cycle.
module vred_scalar_seq #(
    parameter  int XLEN     = 32,
    parameter  int RF_DEPTH = 128,
    parameter  int VL_MAX   = 64,
    localparam int AW       = $clog2(RF_DEPTH),
    localparam int VLW      = $clog2(VL_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [VLW-1:0]  vl,
    input  logic [AW-1:0]   base_idx,
    input  logic [AW-1:0]   acc_idx,
    input  logic            acc_cls,
    input  logic            src_cls,
    input  logic            mapreduce,
    input  logic [2:0]      opcode,
    output logic [AW-1:0]   rf_raddr_acc,
    input  logic [XLEN-1:0] rf_rdata_acc,
    output logic [AW-1:0]   rf_raddr_elem,
    input  logic [XLEN-1:0] rf_rdata_elem,
    output logic            rf_we,
    output logic [AW-1:0]   rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            busy,
    output logic            done,
    output logic            illegal,
    output logic [XLEN-1:0] result
);
    logic           step;
    logic [VLW-1:0] idx;
    logic [AW-1:0]  base_q;
    logic [AW-1:0]  acc_q;
    logic [2:0]     op_q;
    logic [AW-1:0]  elem_addr;
    logic [XLEN-1:0] alu_y;

    vred_ctrl #(.AW(AW), .VLW(VLW), .VL_MAX(VL_MAX)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .vl        (vl),
        .base_idx  (base_idx),
        .acc_idx   (acc_idx),
        .acc_cls   (acc_cls),
        .src_cls   (src_cls),
        .mapreduce (mapreduce),
        .opcode    (opcode),
        .step      (step),
        .busy      (busy),
        .done      (done),
        .illegal   (illegal),
        .idx       (idx),
        .base_q    (base_q),
        .acc_q     (acc_q),
        .op_q      (op_q)
    );

    vred_addr #(.AW(AW), .VLW(VLW)) addr_i (
        .base      (base_q),
        .idx       (idx),
        .elem_addr (elem_addr)
    );

    vred_alu #(.XLEN(XLEN)) alu_i (
        .op   (op_q),
        .acc  (rf_rdata_acc),
        .elem (rf_rdata_elem),
        .y    (alu_y)
    );

    // Register-file port: read both operands, write the accumulator back
    always_comb begin
        rf_raddr_acc  = acc_q;
        rf_raddr_elem = elem_addr;
        rf_we         = step;
        rf_waddr      = acc_q;
        rf_wdata      = alu_y;
    end

    // Final accumulator presented only with a legal done
    always_comb begin
        result = (done && !illegal) ? rf_rdata_acc : '0;
    end
endmodule

// File: rtl/vred_scalar_seq_chk.sv
// Property checker for the reduction sequencer, bound to the top module.
// Keeps its own copy of the accepted request to judge every write.
module vred_scalar_seq_chk #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          illegal,
    input logic          mapreduce,
    input logic [AW-1:0] acc_idx,
    input logic          rf_we,
    input logic [AW-1:0] rf_waddr,
    input logic [AW-1:0] rf_raddr_elem
);
    logic [AW-1:0] acc_cap;
    logic          mr_cap;

    // Capture the request fields when an idle block accepts start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cap <= '0;
            mr_cap  <= 1'b0;
        end else if (start && !busy) begin
            acc_cap <= acc_idx;
            mr_cap  <= mapreduce;
        end
    end

    // R11
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !illegal && !rf_we));

    // R2
    wr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr == acc_cap));

    // R4
    elem_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && $past(rf_we)) |-> (rf_raddr_elem == AW'($past(rf_raddr_elem) + 1'b1)));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && !mr_cap) |=> !rf_we);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !rf_we));
endmodule

bind vred_scalar_seq vred_scalar_seq_chk #(.AW(AW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .illegal       (illegal),
    .mapreduce     (mapreduce),
    .acc_idx       (acc_idx),
    .rf_we         (rf_we),
    .rf_waddr      (rf_waddr),
    .rf_raddr_elem (rf_raddr_elem)
);

// File: tb/vred_scalar_seq_tb.sv
`timescale 1ns/1ps
module vred_scalar_seq_tb_top;

    typedef struct packed {
        logic [6:0] vl;
        logic [6:0] base;
        logic [6:0] acc;
        logic       mr;
        logic [2:0] op;
        logic       acls;
        logic       scls;
        logic [6:0] steps;
        logic       ill;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{7'd8,  7'd10,  7'd3, 1'b1, 3'd0, 1'b0, 1'b0, 7'd8,  1'b0}, // R1 add all
        '{7'd8,  7'd10,  7'd3, 1'b0, 3'd0, 1'b0, 1'b0, 7'd1,  1'b0}, // R3 stop early
        '{7'd5,  7'd20,  7'd4, 1'b1, 3'd1, 1'b0, 1'b0, 7'd5,  1'b0}, // R8 sub
        '{7'd6,  7'd30,  7'd5, 1'b1, 3'd2, 1'b0, 1'b0, 7'd6,  1'b0}, // R8 or
        '{7'd7,  7'd40,  7'd6, 1'b1, 3'd3, 1'b0, 1'b0, 7'd7,  1'b0}, // R8 min
        '{7'd7,  7'd40,  7'd6, 1'b1, 3'd4, 1'b0, 1'b0, 7'd7,  1'b0}, // R8 max
        '{7'd64, 7'd100, 7'd2, 1'b1, 3'd0, 1'b0, 1'b0, 7'd64, 1'b0}, // R4 wrap
        '{7'd0,  7'd0,   7'd1, 1'b1, 3'd0, 1'b0, 1'b0, 7'd0,  1'b0}, // R7
        '{7'd4,  7'd0,   7'd1, 1'b1, 3'd0, 1'b1, 1'b0, 7'd0,  1'b1}, // R5
        '{7'd65, 7'd0,   7'd1, 1'b1, 3'd0, 1'b0, 1'b0, 7'd0,  1'b1}, // R6 vl
        '{7'd4,  7'd0,   7'd1, 1'b1, 3'd5, 1'b0, 1'b0, 7'd0,  1'b1}, // R6 op
        '{7'd4,  7'd8,   7'd9, 1'b1, 3'd0, 1'b0, 1'b0, 7'd4,  1'b0}, // R2 acc inside
        '{7'd3,  7'd60,  7'd0, 1'b1, 3'd4, 1'b1, 1'b1, 7'd3,  1'b0}  // R5 cr/cr
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  vl = '0, base_idx = '0, acc_idx = '0;
    logic        acc_cls = 1'b0, src_cls = 1'b0, mapreduce = 1'b0;
    logic [2:0]  opcode = '0;
    logic [6:0]  rf_raddr_acc, rf_raddr_elem, rf_waddr;
    logic [31:0] rf_rdata_acc, rf_rdata_elem, rf_wdata, result;
    logic        rf_we, busy, done, illegal;

    logic [31:0] rf    [128];
    logic [31:0] model [128];
    logic [31:0] snap  [128];
    logic [6:0]  wlog_elem [1024];
    logic [6:0]  wlog_tgt  [1024];
    int          wcnt = 0;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    vred_scalar_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .base_idx(base_idx),
        .acc_idx(acc_idx), .acc_cls(acc_cls), .src_cls(src_cls),
        .mapreduce(mapreduce), .opcode(opcode),
        .rf_raddr_acc(rf_raddr_acc), .rf_rdata_acc(rf_rdata_acc),
        .rf_raddr_elem(rf_raddr_elem), .rf_rdata_elem(rf_rdata_elem),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .busy(busy), .done(done), .illegal(illegal), .result(result)
    );

    assign rf_rdata_acc  = rf[rf_raddr_acc];
    assign rf_rdata_elem = rf[rf_raddr_elem];

    // Register file write and write log
    always @(posedge clk) begin
        if (rst_n && rf_we) begin
            rf[rf_waddr] <= rf_wdata;
            if (wcnt < 1024) begin
                wlog_elem[wcnt] <= rf_raddr_elem;
                wlog_tgt[wcnt]  <= rf_waddr;
            end
            wcnt <= wcnt + 1;
        end
    end

    function automatic logic [31:0] ref_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a | b;
            3'd3: return (a < b) ? a : b;
            default: return (a > b) ? a : b;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic preload(input int seed);
        for (int i = 0; i < 128; i++) begin
            rf[i]   = (32'h9E3779B9 * 32'(i + 1 + seed * 7)) ^ 32'(i << 4);
            snap[i] = rf[i];
        end
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Drive one request, return falling edges from the sampling edge to done
    task automatic issue(input vec_t v, output int lat);
        @(negedge clk);
        vl = v.vl; base_idx = v.base; acc_idx = v.acc; mapreduce = v.mr;
        opcode = v.op; acc_cls = v.acls; src_cls = v.scls; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        vl = 7'd33; base_idx = 7'd77; acc_idx = 7'd55; opcode = 3'd2;
        lat = 0;
        while (!done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_vec(input vec_t v, input int row);
        int lat, w0, bad_order, bad_tgt, bad_keep;
        logic [31:0] exp;
        string rq;
        preload(row);
        for (int i = 0; i < 128; i++) model[i] = rf[i];
        for (int k = 0; k < int'(v.steps); k++)
            model[v.acc] = ref_op(v.op, model[v.acc], model[7'(v.base + 7'(k))]);
        exp = model[v.acc];
        w0 = wcnt;
        issue(v, lat);
        rq = v.ill ? (v.vl > 7'd64 || v.op > 3'd4 ? "R6" : "R5")
                   : (v.vl == 0 ? "R7" : (v.mr ? "R1" : "R3"));
        check(lat == int'(v.steps), rq, "done latency", 32'(lat), 32'(v.steps));
        check(illegal == v.ill, rq, "illegal flag", 32'(illegal), 32'(v.ill));
        check(wcnt - w0 == int'(v.steps), rq, "write count", 32'(wcnt - w0), 32'(v.steps));
        if (!v.ill) begin
            check(result == exp, "R8", "result", result, exp);
            check(rf[v.acc] == exp, "R2", "accumulator", rf[v.acc], exp);
            bad_order = 0; bad_tgt = 0;
            for (int k = 0; k < int'(v.steps); k++) begin
                if (wlog_elem[w0 + k] != 7'(v.base + 7'(k))) bad_order++;
                if (wlog_tgt[w0 + k] != v.acc) bad_tgt++;
            end
            check(bad_order == 0, "R4", "element order mismatches", 32'(bad_order), 0);
            check(bad_tgt == 0, "R8", "writes off accumulator", 32'(bad_tgt), 0);
        end else begin
            check(result == 0, "R10", "result on reject", result, 0);
            bad_keep = 0;
            for (int i = 0; i < 128; i++) if (rf[i] != snap[i]) bad_keep++;
            check(bad_keep == 0, rq, "registers changed", 32'(bad_keep), 0);
        end
        @(negedge clk);
        check(!done && !illegal, "R10", "done pulse width", 32'(done), 0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int lat, w0, bad_tgt;
        vec_t v;
        preload(0);
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!busy && !done && !illegal && !rf_we, "R11", "outputs in reset",
              {28'd0, busy, done, illegal, rf_we}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !rf_we && result == 0, "R11", "outputs after reset",
              {29'd0, busy, done, rf_we}, 0);

        for (int r = 0; r < NV; r++) run_vec(VECS[r], r);

        // R9: start while busy is ignored
        preload(40);
        w0 = wcnt;
        v = '{7'd10, 7'd50, 7'd7, 1'b1, 3'd0, 1'b0, 1'b0, 7'd10, 1'b0};
        @(negedge clk);
        vl = v.vl; base_idx = v.base; acc_idx = v.acc; mapreduce = 1'b1;
        opcode = 3'd0; acc_cls = 1'b0; src_cls = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(busy && result == 0, "R10", "result while running", result, 0);
        vl = 7'd2; acc_idx = 7'd8; opcode = 3'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 2;
        while (!done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        check(lat == 10, "R9", "latency with extra start", 32'(lat), 10);
        check(wcnt - w0 == 10, "R9", "write count with extra start", 32'(wcnt - w0), 10);
        bad_tgt = 0;
        for (int k = 0; k < 10; k++) if (wlog_tgt[w0 + k] != 7'd7) bad_tgt++;
        check(bad_tgt == 0, "R9", "writes to other register", 32'(bad_tgt), 0);
        check(rf[8] == snap[8], "R9", "second accumulator untouched", rf[8], snap[8]);
        repeat (4) @(negedge clk);
        check(!busy && wcnt - w0 == 10, "R9", "no queued request", 32'(wcnt - w0), 10);

        finish_run();
    end
endmodule